// File: doc/BRIEF.md
# HDLC Event Status Register

This block gathers one-cycle event pulses from an HDLC receiver, an HDLC transmitter and their FIFOs into an 8-bit status word. Each bit is sticky. Once an event sets a bit, the bit holds until the host reads the word. A read strobe returns the current word and clears every bit as a side effect. An event that arrives in the same cycle as the read survives the clear.

Bit 2 is shared between two sources. A select control picks which one drives it: a receive frame abort, or a transmit FIFO underrun (the transmitter tried to read an empty transmit FIFO). Changing the select does not clear bit 2. From that point on, only the newly chosen source can set it.

An 8-bit enable mask is loaded through a write port. The interrupt output is the OR of all status bits that are set and also enabled.

Top module: `hdlc_evt_status`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `stat_q` is 0, `irq` is 0 and `mask_q` equals the `MASK_INIT` parameter.
- R2: A one-cycle pulse sets its status bit, which is visible in `stat_q` one cycle after the pulse. The bit positions are: 7 go-ahead seen, 6 receive end of packet, 5 transmit end of packet (closing flag sent or packet aborted), 4 last byte of a packet at the read side, 3 transmit FIFO below its low level, 1 receive FIFO above its full level, 0 receive FIFO overflow.
- R3: A set bit stays set in every cycle without a read, whatever its source does.
- R4: In a cycle with `rd_stb` high, `stat_q` shows the word before the clear. In the next cycle, every bit with no new event is 0.
- R5: An event in the same cycle as `rd_stb` leaves its bit set in the cycle after the read.
- R6: With `sel_underrun` low, `ev_rx_abort` sets bit 2 and `ev_tx_underrun` has no effect.
- R7: With `sel_underrun` high, `ev_tx_underrun` sets bit 2 and `ev_rx_abort` has no effect.
- R8: Changing `sel_underrun` does not clear bit 2.
- R9: A cycle with `mask_wr` high loads `mask_wdata` into `mask_q`, visible in the next cycle. Bit n of the mask enables status bit n.
- R10: In every cycle, `irq` equals the OR of `stat_q & mask_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_goahead | input | 1 | Go-ahead pattern pulse |
| ev_rx_eop | input | 1 | Receive end-of-packet pulse |
| ev_tx_eop | input | 1 | Transmit end-of-packet pulse |
| ev_eop_read | input | 1 | Last packet byte at read side pulse |
| ev_tx_low | input | 1 | Transmit FIFO low pulse |
| ev_rx_abort | input | 1 | Receive frame abort pulse |
| ev_tx_underrun | input | 1 | Transmit FIFO underrun pulse |
| ev_rx_full | input | 1 | Receive FIFO full-level pulse |
| ev_rx_ovf | input | 1 | Receive FIFO overflow pulse |
| sel_underrun | input | 1 | Bit 2 source select: 0 abort, 1 underrun |
| rd_stb | input | 1 | Status read strobe |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| stat_q | output | 8 | Status word |
| mask_q | output | 8 | Current mask |
| irq | output | 1 | Interrupt, OR of enabled set bits |

## Verification
The bench builds the block with `MASK_INIT` set to 8'h00. This shows that a cleared mask holds `irq` low even while status bits are set, and that the first mask write is what enables the interrupt. The directed sequence then covers:
- each source alone;
- events that coincide with reads;
- both settings of the bit 2 select, including a switch while bit 2 is set;
- masks that enable only some of the bits.

// File: rtl/hdlc_evt_pkg.sv
package hdlc_evt_pkg;
  localparam int ST_W      = 8;
  localparam int B_GOAHEAD = 7;
  localparam int B_RX_EOP  = 6;
  localparam int B_TX_EOP  = 5;
  localparam int B_EOP_RD  = 4;
  localparam int B_TX_LOW  = 3;
  localparam int B_SHARED  = 2;
  localparam int B_RX_FULL = 1;
  localparam int B_RX_OVF  = 0;
endpackage

// File: rtl/hdlc_evt_src_mux.sv
module hdlc_evt_src_mux
  import hdlc_evt_pkg::*;
(
  input  logic            ev_goahead,
  input  logic            ev_rx_eop,
  input  logic            ev_tx_eop,
  input  logic            ev_eop_read,
  input  logic            ev_tx_low,
  input  logic            ev_rx_abort,
  input  logic            ev_tx_underrun,
  input  logic            ev_rx_full,
  input  logic            ev_rx_ovf,
  input  logic            sel_underrun,
  output logic [ST_W-1:0] set_vec
);
  always_comb begin
    set_vec            = '0;
    set_vec[B_GOAHEAD] = ev_goahead;
    set_vec[B_RX_EOP]  = ev_rx_eop;
    set_vec[B_TX_EOP]  = ev_tx_eop;
    set_vec[B_EOP_RD]  = ev_eop_read;
    set_vec[B_TX_LOW]  = ev_tx_low;
    // The shared bit follows the selected source only.
    set_vec[B_SHARED]  = sel_underrun ? ev_tx_underrun : ev_rx_abort;
    set_vec[B_RX_FULL] = ev_rx_full;
    set_vec[B_RX_OVF]  = ev_rx_ovf;
  end
endmodule

// File: rtl/hdlc_evt_sticky.sv
module hdlc_evt_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_stb,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] st_next,
  output logic [W-1:0] st_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // A read drops the old value, but an event in the same cycle still lands.
    assign st_next[i] = rd_stb ? set_vec[i] : (st_q[i] | set_vec[i]);
    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= 1'b0;
      else     st_q[i] <= st_next[i];
    end
  end
endmodule

// File: rtl/hdlc_evt_irq.sv
module hdlc_evt_irq #(
  parameter int           W         = 8,
  parameter logic [W-1:0] MASK_INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] st_next,
  output logic [W-1:0] mask_q,
  output logic         irq
);
  logic [W-1:0] mask_next;

  assign mask_next = mask_wr ? mask_wdata : mask_q;

  // irq is built from next-state values, so it lines up with stat_q and mask_q.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= MASK_INIT;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_next;
      irq    <= |(st_next & mask_next);
    end
  end
endmodule

// File: rtl/hdlc_evt_status.sv
module hdlc_evt_status
  import hdlc_evt_pkg::*;
#(
  parameter logic [ST_W-1:0] MASK_INIT = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_goahead,
  input  logic            ev_rx_eop,
  input  logic            ev_tx_eop,
  input  logic            ev_eop_read,
  input  logic            ev_tx_low,
  input  logic            ev_rx_abort,
  input  logic            ev_tx_underrun,
  input  logic            ev_rx_full,
  input  logic            ev_rx_ovf,
  input  logic            sel_underrun,
  input  logic            rd_stb,
  input  logic            mask_wr,
  input  logic [ST_W-1:0] mask_wdata,
  output logic [ST_W-1:0] stat_q,
  output logic [ST_W-1:0] mask_q,
  output logic            irq
);
  logic [ST_W-1:0] set_vec;
  logic [ST_W-1:0] st_next;

  hdlc_evt_src_mux u_mux (
    .ev_goahead     (ev_goahead),
    .ev_rx_eop      (ev_rx_eop),
    .ev_tx_eop      (ev_tx_eop),
    .ev_eop_read    (ev_eop_read),
    .ev_tx_low      (ev_tx_low),
    .ev_rx_abort    (ev_rx_abort),
    .ev_tx_underrun (ev_tx_underrun),
    .ev_rx_full     (ev_rx_full),
    .ev_rx_ovf      (ev_rx_ovf),
    .sel_underrun   (sel_underrun),
    .set_vec        (set_vec)
  );

  hdlc_evt_sticky #(.W(ST_W)) u_sticky (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .set_vec (set_vec),
    .st_next (st_next),
    .st_q    (stat_q)
  );

  hdlc_evt_irq #(.W(ST_W), .MASK_INIT(MASK_INIT)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .st_next    (st_next),
    .mask_q     (mask_q),
    .irq        (irq)
  );
endmodule

// File: rtl/hdlc_evt_status_chk.sv
module hdlc_evt_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_goahead,
  input logic       ev_rx_abort,
  input logic       ev_tx_underrun,
  input logic       ev_rx_ovf,
  input logic       sel_underrun,
  input logic       rd_stb,
  input logic [7:0] stat_q,
  input logic [7:0] mask_q,
  input logic       irq
);
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3

  AST_READ_CLEAR_TOP: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (stat_q[7] == $past(ev_goahead))); // R4

  AST_READ_KEEPS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && ev_rx_ovf) |=> stat_q[0]); // R5

  AST_ABORT_SETS: assert property (@(posedge clk) disable iff (rst)
    (!sel_underrun && ev_rx_abort) |=> stat_q[2]); // R6

  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (rst)
    (sel_underrun && ev_tx_underrun) |=> stat_q[2]); // R7

  AST_SEL_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_q[2] && !rd_stb && (sel_underrun != $past(sel_underrun))) |=> stat_q[2]); // R8

  AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & mask_q)); // R10
endmodule

bind hdlc_evt_status hdlc_evt_status_chk u_chk (.*);

// File: tb/sim_hdlc_evt_status.sv
`timescale 1ns/1ps
module sim_hdlc_evt_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] ev  = '0; // [8]=underrun, [7..0]: 7 ga,6 rxeop,5 txeop,4 eoprd,3 txlow,2 abort,1 full,0 ovf
  logic       sel = 1'b0;
  logic       rd  = 1'b0;
  logic       mwr = 1'b0;
  logic [7:0] mwd = '0;
  logic [7:0] stat_q, mask_q;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [7:0] m_stat = '0;
  logic [7:0] m_mask = '0;

  always #2.5 clk = ~clk;

  hdlc_evt_status #(.MASK_INIT(8'h00)) u0 (
    .clk(clk), .rst(rst),
    .ev_goahead(ev[7]), .ev_rx_eop(ev[6]), .ev_tx_eop(ev[5]),
    .ev_eop_read(ev[4]), .ev_tx_low(ev[3]), .ev_rx_abort(ev[2]),
    .ev_tx_underrun(ev[8]), .ev_rx_full(ev[1]), .ev_rx_ovf(ev[0]),
    .sel_underrun(sel), .rd_stb(rd), .mask_wr(mwr), .mask_wdata(mwd),
    .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
  );

  always @(posedge clk) begin
    logic [7:0] s;
    s    = ev[7:0];
    s[2] = sel ? ev[8] : ev[2];
    if (rst) begin
      m_stat = '0;
      m_mask = '0;
    end else begin
      m_stat = rd ? s : (m_stat | s);
      if (mwr) m_mask = mwd;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every negedge: compare all outputs against the model.
  always @(negedge clk) begin
    chk("R2 stat_q vs model", stat_q, m_stat);
    chk("R9 mask_q vs model", mask_q, m_mask);
    chk("R10 irq vs model", {7'd0, irq}, {7'd0, |(m_stat & m_mask)});
  end

  // Drive at negedge; result visible at the following negedge.
  task automatic step(input logic [8:0] e, input logic r, input logic s,
                      input logic w = 1'b0, input logic [7:0] d = 8'h00);
    @(negedge clk);
    ev = e; rd = r; sel = s; mwr = w; mwd = d;
    @(posedge clk);
    #1;
    ev = '0; rd = 1'b0; mwr = 1'b0;
  endtask

  task automatic look(input string tag, input logic [7:0] exp);
    @(negedge clk);
    #0.5;
    chk(tag, stat_q, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    look("R1 reset status", 8'h00);
    chk("R1 reset mask", mask_q, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    // R2: each source alone, then read-clear.
    for (int i = 0; i < 8; i++) begin
      step(9'(1 << i), 1'b0, 1'b0);
      look("R2 single event", 8'(1 << i));
      step('0, 1'b1, 1'b0);
      look("R4 cleared after read", 8'h00);
    end

    // R3: accumulate, stays while sources idle.
    step(9'h081, 1'b0, 1'b0);
    step(9'h020, 1'b0, 1'b0);
    repeat (4) step('0, 1'b0, 1'b0);
    look("R3 sticky hold", 8'hA1);

    // R4: during read the word is still visible.
    @(negedge clk);
    rd = 1'b1;
    #0.5 chk("R4 value during read", stat_q, 8'hA1);
    @(posedge clk);
    #1 rd = 1'b0;
    look("R4 cleared", 8'h00);

    // R5: event coinciding with read.
    step(9'h010, 1'b0, 1'b0);
    step(9'h041, 1'b1, 1'b0);
    look("R5 event survives read", 8'h41);
    step('0, 1'b1, 1'b0);

    // R6: sel low, underrun ignored, abort sets.
    step(9'h100, 1'b0, 1'b0);
    look("R6 underrun ignored", 8'h00);
    step(9'h004, 1'b0, 1'b0);
    look("R6 abort sets bit2", 8'h04);
    step('0, 1'b1, 1'b0);

    // R7: sel high, abort ignored, underrun sets.
    step(9'h004, 1'b0, 1'b1);
    look("R7 abort ignored", 8'h00);
    step(9'h100, 1'b0, 1'b1);
    look("R7 underrun sets bit2", 8'h04);

    // R8: switch select while bit2 set.
    step('0, 1'b0, 1'b0);
    look("R8 bit2 kept on select change", 8'h04);
    step(9'h100, 1'b1, 1'b0);
    look("R8 old source ignored after switch", 8'h00);

    // R9/R10: mask behaviour.
    step(9'h002, 1'b0, 1'b0);
    look("R10 masked off no irq", 8'h02);
    chk("R10 irq low with zero mask", {7'd0, irq}, 8'h00);
    step('0, 1'b0, 1'b0, 1'b1, 8'h04);
    chk("R9 mask loaded", mask_q, 8'h04);
    chk("R10 irq low bit not enabled", {7'd0, irq}, 8'h00);
    step('0, 1'b0, 1'b0, 1'b1, 8'h06);
    #1 chk("R10 irq high enabled bit", {7'd0, irq}, 8'h01);
    step('0, 1'b1, 1'b0);
    #1 chk("R10 irq low after read", {7'd0, irq}, 8'h00);
    step(9'h1FF, 1'b0, 1'b1);
    look("R2 all events", 8'hFF);
    step('0, 1'b1, 1'b0);
    repeat (2) step('0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule